// File: doc/BRIEF.md
# Tick-Based PWM Switch Command Generator

This block produces the on/off command for one low-side switch channel. A free-running prescaler divides the 40 MHz system clock into a 2 MHz tick. All timing is counted in those ticks, which gives 500 ns steps. Software supplies an enable, a period and a pulse width, both in ticks. While enabled, the block closes the switch at the start of every period. It holds the switch closed for the pulse-width count and then opens it for the rest of the period.

Parameters supplied on the input ports take effect only at a period boundary, so a pulse is never cut short or stretched. Two duty extremes are steady levels with no glitches: a zero pulse width leaves the switch open, and a pulse width at or above the period leaves it closed. Each time the switch goes from open to closed, a one-clock strobe tells downstream logic (fault sensing, current regulation) that a new pulse has begun.

Top module: `pwm_tick_gen`

## Requirements
- R1: A tick occurs once every CLK_DIV (20) clocks, never on two consecutive clocks. While enabled, the switch command changes only on the clock edge that coincides with a tick.
- R2: Only the low CNT_W (20) bits of the period and width inputs are used. Higher bits are discarded, so a value of 2^20 + n acts as n.
- R3: With period P > 0 and 0 < width W < P, the command is closed for W ticks from the start of each period and then open for P - W ticks. The cycle repeats every P ticks.
- R4: A width of 0 keeps the command open for the whole period.
- R5: A width greater than or equal to the period (P > 0) keeps the command closed without a break across period boundaries.
- R6: When enable is sampled low, the command is open after that clock edge and the counter is idle. After enable rises, the first period starts at the next tick.
- R7: A new period or width presented mid-period takes effect only at the next period boundary. The current period finishes with the values latched at its start.
- R8: A period of 0 holds the command open with no counting. A non-zero value presented later is adopted at the next tick.
- R9: pulse_start is high for exactly the one clock in which sw_close has just gone from 0 to 1, and at no other time.
- R10: A synchronous active-high reset clears the prescaler and the counter, and drives sw_close and pulse_start to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 40 MHz |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| period_in | input | IN_W (24) | Period in ticks; the low CNT_W bits are used |
| width_in | input | IN_W (24) | Pulse width in ticks; the low CNT_W bits are used |
| sw_close | output | 1 | Registered switch command, 1 = closed |
| pulse_start | output | 1 | One-clock strobe on each open-to-closed transition |

## Verification
The hardest case to reach from the ports is a parameter change that lands in the middle of a running period. The bench applies new values at clock counts that are not multiples of the period. Its model then shows whether the old pulse finishes intact and the new shape starts exactly at the boundary. The other hard cases are dropping enable while the switch is closed, a reset during a pulse, and the one-tick period. Each is reached by timing the input change against a known count of clocks since the last reset.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
  parameter int CLK_DIV = 20
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (CLK_DIV <= 1) begin : g_pass
      logic unused_rst;
      assign unused_rst = rst;
      assign tick = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(CLK_DIV);
      localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
        end else if (pre_q == LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + PW'(1);
        end
      end

      assign tick = (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
  import pwm_tick_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [IN_W-1:0]  period_in,
  input  logic [IN_W-1:0]  width_in,
  output logic             nxt_run,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [CNT_W-1:0] nxt_per,
  output logic [CNT_W-1:0] nxt_wid
);

  ch_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic [CNT_W-1:0] per_trim, wid_trim;
  logic             boundary;

  assign per_trim = period_in[CNT_W-1:0];
  assign wid_trim = width_in[CNT_W-1:0];

  generate
    if (IN_W > CNT_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^{period_in[IN_W-1:CNT_W], width_in[IN_W-1:CNT_W]};
    end
  endgenerate

  assign boundary = (st_q == CH_IDLE) || (per_q == '0) ||
                    (cnt_q == per_q - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    per_d = per_q;
    wid_d = wid_q;
    if (!en) begin
      st_d  = CH_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      if (boundary) begin
        st_d  = CH_RUN;
        cnt_d = '0;
        per_d = per_trim;
        wid_d = wid_trim;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      per_q <= per_d;
      wid_q <= wid_d;
    end
  end

  assign nxt_run = (st_d == CH_RUN);
  assign nxt_cnt = cnt_d;
  assign nxt_per = per_d;
  assign nxt_wid = wid_d;

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_run,
  input  logic [CNT_W-1:0] nxt_cnt,
  input  logic [CNT_W-1:0] nxt_per,
  input  logic [CNT_W-1:0] nxt_wid,
  output logic             sw_close,
  output logic             pulse_start
);

  logic close_d;

  // cnt stays below per, so a width at or above the period never opens.
  assign close_d = nxt_run && (nxt_per != '0) && (nxt_cnt < nxt_wid);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_close    <= 1'b0;
      pulse_start <= 1'b0;
    end else begin
      sw_close    <= close_d;
      pulse_start <= close_d && !sw_close;
    end
  end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int CLK_DIV = 20,
  parameter int IN_W    = 24,
  parameter int CNT_W   = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [IN_W-1:0] period_in,
  input  logic [IN_W-1:0] width_in,
  output logic            sw_close,
  output logic            pulse_start
);

  logic             tick_w;
  logic             nxt_run;
  logic [CNT_W-1:0] nxt_cnt, nxt_per, nxt_wid;

  pwm_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_w)
  );

  pwm_period_core #(.IN_W(IN_W), .CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tick      (tick_w),
    .period_in (period_in),
    .width_in  (width_in),
    .nxt_run   (nxt_run),
    .nxt_cnt   (nxt_cnt),
    .nxt_per   (nxt_per),
    .nxt_wid   (nxt_wid)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .nxt_run     (nxt_run),
    .nxt_cnt     (nxt_cnt),
    .nxt_per     (nxt_per),
    .nxt_wid     (nxt_wid),
    .sw_close    (sw_close),
    .pulse_start (pulse_start)
  );

endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick,
  input logic sw_close,
  input logic pulse_start
);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_edge_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(tick) && !$past(rst)) |-> $stable(sw_close));

  assert_disabled_open_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sw_close);

  assert_strobe_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> $rose(sw_close));

  assert_rise_has_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_close) |-> pulse_start);

  assert_reset_open_R10: assert property (@(posedge clk)
    rst |=> (!sw_close && !pulse_start));

endmodule

bind pwm_tick_gen pwm_tick_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .tick        (tick_w),
  .sw_close    (sw_close),
  .pulse_start (pulse_start)
);

// File: tb/sim_pwm_tick_gen.sv
`timescale 1ns/1ps
module sim_pwm_tick_gen;

  localparam int DIV  = 20;
  localparam int MASK = 'hFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [23:0] period_in = '0;
  logic [23:0] width_in = '0;
  logic        sw_close, pulse_start;

  int    vectors = 0;
  int    miscompares = 0;
  bit    started = 0;
  bit    finished = 0;
  string cur_req = "R10";

  // behavioural reference state
  int m_pre = 0, m_cnt = 0, m_per = 0, m_wid = 0;
  bit m_run = 0, m_close = 0, m_strb = 0;

  always #2 clk = ~clk;

  pwm_tick_gen u0 (
    .clk(clk), .rst(rst), .en(en), .period_in(period_in),
    .width_in(width_in), .sw_close(sw_close), .pulse_start(pulse_start)
  );

  always @(posedge clk) begin
    bit tk, nc;
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_per = 0; m_wid = 0;
      m_run = 0; m_close = 0; m_strb = 0;
    end else begin
      tk = (m_pre == DIV - 1);
      m_pre = tk ? 0 : m_pre + 1;
      if (!en) begin
        m_run = 0;
        m_cnt = 0;
      end else if (tk) begin
        if (!m_run || m_per == 0 || m_cnt == m_per - 1) begin
          m_per = int'(period_in) & MASK;
          m_wid = int'(width_in) & MASK;
          m_cnt = 0;
          m_run = 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      nc = m_run && (m_per != 0) && (m_cnt < m_wid);
      m_strb = nc && !m_close;
      m_close = nc;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      if (sw_close !== m_close) begin
        miscompares++;
        $display("FAIL %s sw_close actual=%b expected=%b at t=%0t",
                 cur_req, sw_close, m_close, $time);
      end
      if (pulse_start !== m_strb) begin
        miscompares++;
        $display("FAIL %s pulse_start actual=%b expected=%b at t=%0t",
                 cur_req, pulse_start, m_strb, $time);
      end
    end
  end

  task automatic phase(input string req, input bit e, input int per,
                       input int wid, input int cycles);
    @(negedge clk);
    cur_req   = req;
    en        = e;
    period_in = 24'(per);
    width_in  = 24'(wid);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #400000;
    $display("FAIL watchdog expired, run hung");
    miscompares++;
    finish_run();
  end

  initial begin
    cur_req = "R10";
    repeat (10) @(negedge clk);
    rst = 1'b0;
    phase("R6",  0, 4, 2, 100);          // disabled: held open
    phase("R3",  1, 5, 2, 430);          // 40% duty, several periods
    phase("R7",  1, 5, 0, 37);           // change mid-period, old pulse completes
    phase("R4",  1, 5, 0, 300);          // zero width
    phase("R7",  1, 3, 2, 45);           // back to pulsing, adopted at boundary
    phase("R3",  1, 3, 2, 200);
    phase("R5",  1, 5, 7, 400);          // width above period
    phase("R5",  1, 3, 3, 200);          // width equal to period
    phase("R8",  1, 0, 3, 200);          // zero period
    phase("R8",  1, 4, 1, 200);          // leave zero period at next tick
    phase("R2",  1, 'hF00004, 'hA00001, 400); // upper bits discarded
    phase("R5",  1, 1, 1, 100);          // one-tick period
    phase("R6",  1, 6, 4, 133);
    phase("R6",  0, 6, 4, 60);           // drop enable while closed
    phase("R6",  1, 6, 4, 207);          // re-enable, start at next tick
    @(negedge clk); cur_req = "R10"; rst = 1'b1;
    repeat (5) @(negedge clk); rst = 1'b0;
    phase("R1",  1, 2, 1, 200);
    phase("R9",  1, 3, 1, 240);
    phase("R1",  1, 'h100002, 'h100001, 160); // 2^20 wrap still works
    finish_run();
  end

endmodule